// File: doc/BRIEF.md
# UART Transmitter with CTS Gating

This block is the serializer for one asynchronous serial channel. When data is waiting, it takes one byte at a time from a transmit FIFO. It does this through a pop strobe and sees the FIFO only through its empty flag and head byte. It sends each byte as a frame: one low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a stop period of 1, 1.5 or 2 bits. Bit timing comes from an external sample-clock enable, and each bit lasts 16 enable pulses or 8 enable pulses. The frame settings are captured when the byte is popped, so a frame never changes shape halfway through.

An optional flow-control mode makes every new frame wait for the active-low clear-to-send input. From idle, a frame starts only on a tick where clear-to-send is active. When frames run back to back, clear-to-send is sampled once, half a bit time before the end of the stop period. That sample decides whether the next frame follows at once. A frame that has started always runs to its end. A break input pulls the line low for as long as it is held, and it does not disturb the frame timing.

Top module: `uart_tx_cts`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd_o` is 1 (unless break is held), `busy_o` is 0 and `pop_o` is 0.
- R2: On a tick while idle, with `fifo_empty_i` low and the flow gate open, `pop_o` is high for that one cycle. From the next cycle on, `busy_o` is 1 and the line is 0 for one bit time (the start bit).
- R3: `wlen_i` selects the data length: 0=5, 1=6, 2=7, 3=8 bits. Data bits follow the start bit, least significant bit first, each lasting one bit time.
- R4: With `par_en_i`=1, one parity bit follows the data. `par_odd_i`=0 makes the count of ones in data plus parity even; `par_odd_i`=1 makes it odd. With `par_en_i`=0, no parity bit is sent.
- R5: With `stop_long_i`=0 the stop period is 1 bit. With `stop_long_i`=1 and a 5-bit character it is 1.5 bits (24 ticks at 16x, 12 ticks at 8x). With `stop_long_i`=1 and any other length it is 2 bits. The line is 1 throughout the stop period.
- R6: `os8_i`=0 makes one bit last 16 ticks; `os8_i`=1 makes it last 8 ticks.
- R7: If a byte is waiting when the final stop tick occurs and the gate allows it, the next frame is popped on that same tick. Its start bit then follows with no idle cycle.
- R8: With `acts_en_i`=1, a frame starts from idle only on a tick where `cts_ni` is 0. While `cts_ni` is 1 the block stays idle and leaves the FIFO untouched.
- R9: With `acts_en_i`=1, `cts_ni` is sampled on the stop-period tick that lies half a bit time (8 or 4 ticks) before the frame end. A high sample sends the block to idle instead of chaining. A low sample chains even if `cts_ni` rises afterwards. A frame in progress always completes.
- R10: With `acts_en_i`=0, `cts_ni` has no effect on popping or timing.
- R11: While `brk_i` is 1, `txd_o` is 0. Frame timing and popping carry on unchanged.
- R12: Word length, parity, stop length and sample rate are captured at the pop. Changes during a frame apply from the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample-clock enable, one pulse per sample period |
| os8_i | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| wlen_i | input | 2 | Data length code (5 + value bits) |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| stop_long_i | input | 1 | 0: one stop bit; 1: 1.5 (5-bit) or 2 stop bits |
| acts_en_i | input | 1 | Enable clear-to-send gating of new frames |
| cts_ni | input | 1 | Clear-to-send, active low, synchronous to clk_i |
| brk_i | input | 1 | Force the serial line low |
| fifo_empty_i | input | 1 | Transmit FIFO empty flag |
| fifo_data_i | input | 8 | Byte at the FIFO head |
| pop_o | output | 1 | Pop strobe, one cycle per byte taken |
| txd_o | output | 1 | Serial output, idle high |
| busy_o | output | 1 | A frame is in progress |

## Verification
The hardest situation to reach is the handover between frames under flow control. Clear-to-send has to change within a few ticks of the single sample point in the stop period, on both sides of it, while a second byte is already waiting. The stimulus reaches this by watching the bench's own tick-level model of the frame, which knows how many ticks are left. It raises clear-to-send a few ticks before the sample in one case and a few ticks after it in another. The outputs are compared with the model on every clock, and the FIFO fill is checked to show whether the second byte was taken.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int MAX_BITS = 8;
  localparam int IDX_W    = $clog2(MAX_BITS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_odd;
    logic       stop_long;
    logic       os8;
  } tx_cfg_t;

  function automatic logic [IDX_W-1:0] last_bit_idx(input logic [1:0] wlen);
    return IDX_W'(4 + int'(wlen));
  endfunction
endpackage

// File: rtl/uart_tx_seg_cnt.sv
module uart_tx_seg_cnt #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic [CW-1:0] seg_len_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  assign last_o = run_i && tick_i && (cnt_q == seg_len_i - CW'(1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= last_o ? '0 : cnt_q + CW'(1);
  end

  // R5
  cnt_in_seg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < seg_len_i));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    wlen_i,
  input  logic          par_odd_i,
  output logic          bit_o,
  output logic          par_o
);
  logic [DW-1:0] sh_q;
  logic [DW-1:0] mask;
  logic          par_q;

  assign mask = {DW{1'b1}} >> (DW - 5 - int'(wlen_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      par_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= data_i;
      par_q <= (^(data_i & mask)) ^ par_odd_i;
    end else if (shift_i) begin
      sh_q  <= sh_q >> 1;
    end
  end

  assign bit_o = sh_q[0];
  assign par_o = par_q;
endmodule

// File: rtl/uart_tx_cts_gate.sv
module uart_tx_cts_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cts_ni,
  input  logic sample_i,
  output logic idle_ok_o,
  output logic chain_ok_o
);
  logic ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ok_q <= 1'b0;
    else if (sample_i) ok_q <= !cts_ni;
  end

  assign idle_ok_o  = !en_i || !cts_ni;
  assign chain_ok_o = !en_i || ok_q;

  // R9
  cts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(ok_q));
endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts
  import uart_tx_pkg::*;
#(
  parameter int OS_HI = 16,
  parameter int OS_LO = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                os8_i,
  input  logic [1:0]          wlen_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                stop_long_i,
  input  logic                acts_en_i,
  input  logic                cts_ni,
  input  logic                brk_i,
  input  logic                fifo_empty_i,
  input  logic [MAX_BITS-1:0] fifo_data_i,
  output logic                pop_o,
  output logic                txd_o,
  output logic                busy_o
);
  localparam int CW = $clog2(2 * OS_HI + 1);

  tx_state_e        state_q, state_d;
  tx_cfg_t          cfg_q;
  logic [IDX_W-1:0] bit_q;
  logic [CW-1:0]    bit_len, half_len, stop_len, seg_len, cnt;
  logic             seg_last, line, sh_bit, par_bit;
  logic             idle_ok, chain_ok, sample, start_idle, chain, load, shift;

  always_comb begin
    bit_len  = cfg_q.os8 ? CW'(OS_LO) : CW'(OS_HI);
    half_len = bit_len >> 1;
    if (!cfg_q.stop_long)       stop_len = bit_len;
    else if (cfg_q.wlen == 2'd0) stop_len = bit_len + half_len;
    else                         stop_len = bit_len << 1;
    seg_len = (state_q == ST_STOP) ? stop_len : bit_len;
  end

  uart_tx_seg_cnt #(.CW(CW)) u_seg_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .run_i     (state_q != ST_IDLE),
    .seg_len_i (seg_len),
    .cnt_o     (cnt),
    .last_o    (seg_last)
  );

  // sample half a bit before the end of the stop period
  assign sample = (state_q == ST_STOP) && tick_i && (cnt == stop_len - half_len);

  uart_tx_cts_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (acts_en_i),
    .cts_ni     (cts_ni),
    .sample_i   (sample),
    .idle_ok_o  (idle_ok),
    .chain_ok_o (chain_ok)
  );

  assign start_idle = (state_q == ST_IDLE) && tick_i && !fifo_empty_i && idle_ok;
  assign chain      = (state_q == ST_STOP) && seg_last && !fifo_empty_i && chain_ok;
  assign load       = start_idle || chain;
  assign shift      = (state_q == ST_DATA) && seg_last;

  uart_tx_shift #(.DW(MAX_BITS)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .shift_i   (shift),
    .data_i    (fifo_data_i),
    .wlen_i    (wlen_i),
    .par_odd_i (par_odd_i),
    .bit_o     (sh_bit),
    .par_o     (par_bit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_idle) state_d = ST_START;
      ST_START: if (seg_last)   state_d = ST_DATA;
      ST_DATA:  if (seg_last && bit_q == last_bit_idx(cfg_q.wlen))
                  state_d = cfg_q.par_en ? ST_PAR : ST_STOP;
      ST_PAR:   if (seg_last)   state_d = ST_STOP;
      ST_STOP:  if (seg_last)   state_d = chain ? ST_START : ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load) begin
        cfg_q <= '{wlen: wlen_i, par_en: par_en_i, par_odd: par_odd_i,
                   stop_long: stop_long_i, os8: os8_i};
      end
      if (state_q == ST_START) bit_q <= '0;
      else if (shift)          bit_q <= bit_q + IDX_W'(1);
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh_bit;
      ST_PAR:   line = par_bit;
      default:  line = 1'b1;
    endcase
  end

  assign txd_o  = line && !brk_i;
  assign busy_o = (state_q != ST_IDLE);
  assign pop_o  = load;

  // R2
  pop_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> (tick_i && !fifo_empty_i));
  // R2
  start_bit_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o && !busy_o) |=> (brk_i || !txd_o));
  // R11
  break_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> !txd_o);
  // R8
  idle_cts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acts_en_i && !busy_o && cts_ni) |-> !pop_o);
  // R9
  frame_end_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(tick_i));
endmodule

// File: tb/uart_tx_cts_bench.sv
module uart_tx_cts_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic os8 = 1'b0, par_en = 1'b0, par_odd = 1'b0, stop_long = 1'b0;
  logic acts = 1'b0, cts_n = 1'b0, brk = 1'b0;
  logic [1:0] wlen = 2'd3;
  logic fifo_empty = 1'b1;
  logic [7:0] fifo_data = 8'h00;
  logic pop, txd, busy;

  int checks = 0, fails = 0;
  string req = "R1";
  logic [7:0] fifo_q[$];
  int mq[$];
  int m_len = 0;
  bit m_ok = 1'b0;
  bit pend_pop = 1'b0;
  int tdiv = 1, tcnt = 0;

  always #4 clk = ~clk;

  uart_tx_cts u_uart_tx_cts (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .os8_i(os8), .wlen_i(wlen),
    .par_en_i(par_en), .par_odd_i(par_odd), .stop_long_i(stop_long),
    .acts_en_i(acts), .cts_ni(cts_n), .brk_i(brk), .fifo_empty_i(fifo_empty),
    .fifo_data_i(fifo_data), .pop_o(pop), .txd_o(txd), .busy_o(busy)
  );

  task automatic refresh();
    fifo_empty = (fifo_q.size() == 0);
    fifo_data  = fifo_empty ? 8'h00 : fifo_q[0];
  endtask

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // one queue entry per tick of line level
  task automatic build(input logic [7:0] d);
    int l, n, s;
    logic p;
    l = os8 ? 8 : 16;
    n = 5 + int'(wlen);
    m_len = l;
    repeat (l) mq.push_back(0);
    for (int i = 0; i < n; i++) repeat (l) mq.push_back(int'(d[i]));
    if (par_en) begin
      p = par_odd;
      for (int i = 0; i < n; i++) p ^= d[i];
      repeat (l) mq.push_back(int'(p));
    end
    s = !stop_long ? l : (n == 5 ? l + l / 2 : 2 * l);
    repeat (s) mq.push_back(1);
  endtask

  always @(posedge clk) begin
    #1;
    if (pend_pop) begin
      void'(fifo_q.pop_front());
      pend_pop = 1'b0;
    end
    tcnt = (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
    tick = (tcnt == 0);
    refresh();
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic ebusy, eline, estart, epop;
      ebusy = (mq.size() != 0);
      eline = ebusy ? mq[0][0] : 1'b1;
      if (mq.size() == 0)      estart = !fifo_empty && (!acts || !cts_n);
      else if (mq.size() == 1) estart = !fifo_empty && (!acts || m_ok);
      else                     estart = 1'b0;
      epop = tick && estart;
      chk("txd", txd, eline && !brk);
      chk("busy", busy, ebusy);
      chk("pop", pop, epop);
      if (tick) begin
        if (mq.size() != 0 && mq.size() == m_len / 2) m_ok = !cts_n;
        if (mq.size() != 0) void'(mq.pop_front());
        if (epop) begin
          build(fifo_q[0]);
          pend_pop = 1'b1;
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic push(input logic [7:0] d);
    fifo_q.push_back(d);
    refresh();
  endtask

  task automatic drain();
    while (fifo_q.size() != 0 || mq.size() != 0 || pend_pop) step();
    repeat (3) step();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired in %s", req);
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("reset txd", txd, 1'b1);
    chk("reset busy", busy, 1'b0);
    chk("reset pop", pop, 1'b0);
    step(); rst_n = 1'b1;
    repeat (5) step();
    @(negedge clk);
    chk("idle txd", txd, 1'b1);
    chk("idle busy", busy, 1'b0);

    // R2 / R3 8-bit, 16x
    req = "R2"; step(); push(8'hA5); drain();
    req = "R3";
    for (int w = 0; w < 4; w++) begin
      wlen = w[1:0]; push(8'hD6); push(8'h3B); drain();
    end
    // R4 parity
    req = "R4";
    for (int k = 0; k < 4; k++) begin
      par_en = 1'b1; par_odd = k[0]; wlen = k[1] ? 2'd3 : 2'd1;
      push(8'h96); push(8'h01); drain();
    end
    par_en = 1'b0;
    // R5 stop lengths
    req = "R5";
    stop_long = 1'b1; wlen = 2'd0; push(8'h15); drain();
    os8 = 1'b1; push(8'h0A); drain();
    os8 = 1'b0; wlen = 2'd2; push(8'h55); drain();
    stop_long = 1'b0;
    // R6 8x with sparse ticks
    req = "R6";
    os8 = 1'b1; tdiv = 3; wlen = 2'd3; push(8'hC3); push(8'h7E); drain();
    os8 = 1'b0; tdiv = 1;
    // R7 back to back
    req = "R7";
    push(8'h11); push(8'h22); push(8'h33);
    while (!busy) step();
    while (fifo_q.size() != 0) begin
      step();
      @(negedge clk);
      chk("busy during chain", busy, 1'b1);
    end
    drain();

    // R8 idle hold under CTS
    req = "R8";
    acts = 1'b1; cts_n = 1'b1; push(8'h5A);
    repeat (200) step();
    @(negedge clk);
    chk("held busy", busy, 1'b0);
    chk_int("held fifo", fifo_q.size(), 1);
    step(); cts_n = 1'b0; drain();

    // R9 CTS raised before sample point: no chain
    req = "R9";
    push(8'hF0); push(8'h0F);
    while (!(mq.size() > 0 && mq.size() <= m_len / 2 + 3 && fifo_q.size() == 1)) step();
    cts_n = 1'b1;
    repeat (60) step();
    @(negedge clk);
    chk("no chain busy", busy, 1'b0);
    chk_int("no chain fifo", fifo_q.size(), 1);
    step(); cts_n = 1'b0; drain();
    // R9 CTS raised after sample point: chain goes ahead
    push(8'h81); push(8'h42);
    while (!(mq.size() > 0 && mq.size() <= 2 && fifo_q.size() == 1)) step();
    cts_n = 1'b1;
    repeat (20) step();
    @(negedge clk);
    chk_int("chain fifo", fifo_q.size(), 0);
    chk("chain busy", busy, 1'b1);
    drain();
    step(); cts_n = 1'b0;

    // R10 CTS ignored when gating off
    req = "R10";
    acts = 1'b0; cts_n = 1'b1; push(8'h99); push(8'h66); drain();
    @(negedge clk);
    chk_int("ignored fifo", fifo_q.size(), 0);
    step(); cts_n = 1'b0;

    // R11 break
    req = "R11";
    brk = 1'b1; repeat (3) step();
    @(negedge clk);
    chk("break idle", txd, 1'b0);
    step(); brk = 1'b0;
    push(8'hFF); push(8'hAA);
    repeat (40) step(); brk = 1'b1;
    repeat (50) step(); brk = 1'b0;
    drain();

    // R12 config captured at pop
    req = "R12";
    wlen = 2'd3; push(8'hE7);
    while (!busy) step();
    repeat (20) step();
    wlen = 2'd0; par_en = 1'b1; stop_long = 1'b1; os8 = 1'b1;
    push(8'h1C);
    drain();
    wlen = 2'd3; par_en = 1'b0; stop_long = 1'b0; os8 = 1'b0;

    req = "R1";
    repeat (5) step();
    @(negedge clk);
    chk("final idle txd", txd, 1'b1);
    chk("final idle busy", busy, 1'b0);
    finish_run();
  end
endmodule